// File: doc/BRIEF.md
# Dual Mask Register Unit

This unit keeps the two 64-bit masks that a content-addressable memory applies to its searches and to its write traffic. Mask 1 has two copies, an active (foreground) one and a parked (background) one. A single swap command exchanges them, so software can switch between two masking contexts in one clock. Mask 2 has a single copy that can be moved one bit position left or right per command. Either mask, or no mask at all, can be chosen as the current mask.

The unit receives strobes that are already decoded, and each mask is written 16 bits at a time. It drives the chosen mask to the comparison logic. A 1 in the mask tells that logic to ignore the corresponding comparand bit for every stored entry. The unit also merges an old destination word with a new word under the chosen mask, so that masked bits keep their old value. It does not contain the array, the comparand or the instruction decoding.

Top module: `mask_pair_unit`

## Requirements
- R1: After reset, every mask copy is zero and no mask is chosen. As a result, `selMask` reads zero and `mergeWord` equals `newWord`.
- R2: A load with `loadStb` = 1 writes `segData` into bits [16*k+15 : 16*k] of its target, where k = `segIdx` (0 holds bits 15..0 and 3 holds bits 63..48). Every other bit of the target is left unchanged. `loadTgt` selects the target: 0 = mask 1 foreground, 1 = mask 1 background, 2 = mask 2, 3 = nothing.
- R3: `swapStb` exchanges the foreground and background copies of mask 1 at the next clock edge.
- R4: Only the foreground copy of mask 1 reaches `selMask`. A load into the background copy leaves `selMask` unchanged until a swap.
- R5: `shiftStb` with `shiftLeft` = 1 moves mask 2 up by one bit. A 0 enters bit 0 and the old bit 63 is lost.
- R6: `shiftStb` with `shiftLeft` = 0 moves mask 2 down by one bit. A 0 enters bit 63 and the old bit 0 is lost.
- R7: `selStb` stores `selIn` as the current choice, which holds until the next `selStb`. The codes are 0 = none, 1 = mask 1, 2 = mask 2, 3 = none. `selMask` is the chosen mask, or zero when none is chosen. A 1 in `selMask` marks a don't-care comparand bit.
- R8: `mergeWord` = (`selMask` & `oldWord`) | (~`selMask` & `newWord`) in the same cycle. Masked bits keep the old value.
- R9: When several mask-changing strobes arrive in one cycle, load wins over swap and swap wins over shift. The losing commands are dropped. A load with target 3 still wins. `selStb` acts independently of all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| loadStb | input | 1 | Segment load strobe |
| loadTgt | input | 2 | Load target code |
| segIdx | input | 2 | Segment number of the load |
| segData | input | 16 | Segment write data |
| swapStb | input | 1 | Exchange mask 1 copies |
| shiftStb | input | 1 | Shift mask 2 by one bit |
| shiftLeft | input | 1 | Shift direction, 1 = toward bit 63 |
| selStb | input | 1 | Store a new mask choice |
| selIn | input | 2 | Mask choice code |
| oldWord | input | 64 | Current destination contents |
| newWord | input | 64 | Incoming write data |
| selMask | output | 64 | Chosen mask, 1 = don't care / keep |
| mergeWord | output | 64 | Masked merge of old and new words |

## Verification
All load, swap, shift and select commands are sampled at a rising edge. Their effect on `selMask` is due just after that same edge, because a single register stage sits between the strobe and the output. `mergeWord` has no register stage and follows `oldWord` and `newWord` within the cycle. The bench therefore drives strobes at the falling edge and samples 1 ns after the following rising edge. It changes the merge operands only between edges and reads `mergeWord` before the next edge.

// File: rtl/mask_pair_pkg.sv
package mask_pair_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_M1   = 2'd1,
    SEL_M2   = 2'd2,
    SEL_OFF  = 2'd3
  } maskSel_e;

  typedef enum logic [1:0] {
    TGT_FG   = 2'd0,
    TGT_BG   = 2'd1,
    TGT_M2   = 2'd2,
    TGT_NONE = 2'd3
  } loadTgt_e;

  // one-hot-or-zero strobes from control to datapath
  typedef struct packed {
    logic wrFg;
    logic wrBg;
    logic wrM2;
    logic swap;
    logic shiftUp;
    logic shiftDown;
  } maskOps_t;

endpackage

// File: rtl/mask_pair_ctrl.sv
module mask_pair_ctrl
  import mask_pair_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadStb,
  input  logic [1:0] loadTgt,
  input  logic       swapStb,
  input  logic       shiftStb,
  input  logic       shiftLeft,
  input  logic       selStb,
  input  logic [1:0] selIn,
  output maskOps_t   ops,
  output maskSel_e   selCur
);

  // priority: load > swap > shift
  always_comb begin
    ops = '0;
    if (loadStb) begin
      unique case (loadTgt_e'(loadTgt))
        TGT_FG:   ops.wrFg = 1'b1;
        TGT_BG:   ops.wrBg = 1'b1;
        TGT_M2:   ops.wrM2 = 1'b1;
        default:  ops    = '0;
      endcase
    end else if (swapStb) begin
      ops.swap = 1'b1;
    end else if (shiftStb) begin
      ops.shiftUp   = shiftLeft;
      ops.shiftDown = ~shiftLeft;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selCur <= SEL_NONE;
    end else if (selStb) begin
      selCur <= maskSel_e'(selIn);
    end
  end

endmodule

// File: rtl/mask_pair_dp.sv
module mask_pair_dp
  import mask_pair_pkg::*;
#(
  parameter int MASK_W = 64,
  parameter int SEG_W  = 16,
  localparam int NSEG      = MASK_W / SEG_W,
  localparam int SEG_IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  maskOps_t             ops,
  input  logic [SEG_IDX_W-1:0] segIdx,
  input  logic [SEG_W-1:0]     segData,
  input  maskSel_e             selCur,
  input  logic [MASK_W-1:0]    oldWord,
  input  logic [MASK_W-1:0]    newWord,
  output logic [MASK_W-1:0]    m1Fg,
  output logic [MASK_W-1:0]    m1Bg,
  output logic [MASK_W-1:0]    m2Val,
  output logic [MASK_W-1:0]    selMask,
  output logic [MASK_W-1:0]    mergeWord
);

  logic [MASK_W-1:0] segBits;
  logic [MASK_W-1:0] loadBits;
  logic [MASK_W-1:0] nextFg;
  logic [MASK_W-1:0] nextBg;
  logic [MASK_W-1:0] nextM2;

  // lane enables for the addressed segment
  for (genvar g = 0; g < NSEG; g++) begin : gSeg
    assign segBits[g*SEG_W +: SEG_W]  = {SEG_W{segIdx == SEG_IDX_W'(g)}};
    assign loadBits[g*SEG_W +: SEG_W] = segData;
  end

  always_comb begin
    nextFg = m1Fg;
    nextBg = m1Bg;
    nextM2 = m2Val;
    if (ops.wrFg) begin
      nextFg = (m1Fg & ~segBits) | (loadBits & segBits);
    end
    if (ops.wrBg) begin
      nextBg = (m1Bg & ~segBits) | (loadBits & segBits);
    end
    if (ops.swap) begin
      nextFg = m1Bg;
      nextBg = m1Fg;
    end
    if (ops.wrM2) begin
      nextM2 = (m2Val & ~segBits) | (loadBits & segBits);
    end else if (ops.shiftUp) begin
      nextM2 = {m2Val[MASK_W-2:0], 1'b0};
    end else if (ops.shiftDown) begin
      nextM2 = {1'b0, m2Val[MASK_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      m1Fg  <= '0;
      m1Bg  <= '0;
      m2Val <= '0;
    end else begin
      m1Fg  <= nextFg;
      m1Bg  <= nextBg;
      m2Val <= nextM2;
    end
  end

  always_comb begin
    unique case (selCur)
      SEL_M1:  selMask = m1Fg;
      SEL_M2:  selMask = m2Val;
      default: selMask = '0;
    endcase
  end

  assign mergeWord = (selMask & oldWord) | (~selMask & newWord);

endmodule

// File: rtl/mask_pair_unit.sv
module mask_pair_unit
  import mask_pair_pkg::*;
#(
  parameter int MASK_W = 64,
  parameter int SEG_W  = 16,
  localparam int NSEG      = MASK_W / SEG_W,
  localparam int SEG_IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadStb,
  input  logic [1:0]           loadTgt,
  input  logic [SEG_IDX_W-1:0] segIdx,
  input  logic [SEG_W-1:0]     segData,
  input  logic                 swapStb,
  input  logic                 shiftStb,
  input  logic                 shiftLeft,
  input  logic                 selStb,
  input  logic [1:0]           selIn,
  input  logic [MASK_W-1:0]    oldWord,
  input  logic [MASK_W-1:0]    newWord,
  output logic [MASK_W-1:0]    selMask,
  output logic [MASK_W-1:0]    mergeWord
);

  maskOps_t          ops;
  maskSel_e          selCur;
  logic [MASK_W-1:0] m1Fg;
  logic [MASK_W-1:0] m1Bg;
  logic [MASK_W-1:0] m2Val;

  mask_pair_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadStb   (loadStb),
    .loadTgt   (loadTgt),
    .swapStb   (swapStb),
    .shiftStb  (shiftStb),
    .shiftLeft (shiftLeft),
    .selStb    (selStb),
    .selIn     (selIn),
    .ops       (ops),
    .selCur    (selCur)
  );

  mask_pair_dp #(.MASK_W(MASK_W), .SEG_W(SEG_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ops       (ops),
    .segIdx    (segIdx),
    .segData   (segData),
    .selCur    (selCur),
    .oldWord   (oldWord),
    .newWord   (newWord),
    .m1Fg      (m1Fg),
    .m1Bg      (m1Bg),
    .m2Val     (m2Val),
    .selMask   (selMask),
    .mergeWord (mergeWord)
  );

endmodule

// File: rtl/mask_pair_chk.sv
module mask_pair_chk
  import mask_pair_pkg::*;
#(
  parameter int MASK_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadStb,
  input logic [1:0]        loadTgt,
  input logic              swapStb,
  input logic              shiftStb,
  input logic              shiftLeft,
  input maskSel_e          selCur,
  input logic [MASK_W-1:0] m1Fg,
  input logic [MASK_W-1:0] m1Bg,
  input logic [MASK_W-1:0] m2Val,
  input logic [MASK_W-1:0] selMask,
  input logic [MASK_W-1:0] mergeWord,
  input logic [MASK_W-1:0] oldWord,
  input logic [MASK_W-1:0] newWord
);

  AST_SWAP_EXCHANGES: assert property (@(posedge clk) disable iff (!rstN)
    (swapStb && !loadStb) |=> (m1Fg == $past(m1Bg)) && (m1Bg == $past(m1Fg))); // R3

  AST_BG_LOAD_HIDDEN: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && loadTgt == 2'd1) |=> $stable(m1Fg)); // R4

  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rstN)
    (shiftStb && shiftLeft && !loadStb && !swapStb) |=> (m2Val == ($past(m2Val) << 1))); // R5

  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (shiftStb && !shiftLeft && !loadStb && !swapStb) |=> (m2Val == ($past(m2Val) >> 1))); // R6

  AST_NONE_IS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (selCur == SEL_NONE || selCur == SEL_OFF) |-> (selMask == '0)); // R7

  AST_MERGE_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rstN)
    ((selMask & (mergeWord ^ oldWord)) == '0) && ((~selMask & (mergeWord ^ newWord)) == '0)); // R8

  AST_LOAD_BLOCKS_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && loadTgt != 2'd2) |=> $stable(m2Val)); // R9

endmodule

bind mask_pair_unit mask_pair_chk #(.MASK_W(MASK_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .loadStb   (loadStb),
  .loadTgt   (loadTgt),
  .swapStb   (swapStb),
  .shiftStb  (shiftStb),
  .shiftLeft (shiftLeft),
  .selCur    (selCur),
  .m1Fg      (m1Fg),
  .m1Bg      (m1Bg),
  .m2Val     (m2Val),
  .selMask   (selMask),
  .mergeWord (mergeWord),
  .oldWord   (oldWord),
  .newWord   (newWord)
);

// File: tb/sim_mask_pair_unit.sv
`timescale 1ns/1ps
module sim_mask_pair_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        loadStb, swapStb, shiftStb, shiftLeft, selStb;
  logic [1:0]  loadTgt, segIdx, selIn;
  logic [15:0] segData;
  logic [63:0] oldWord, newWord, selMask, mergeWord;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mask_pair_unit u0 (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .loadTgt(loadTgt),
    .segIdx(segIdx), .segData(segData), .swapStb(swapStb),
    .shiftStb(shiftStb), .shiftLeft(shiftLeft), .selStb(selStb),
    .selIn(selIn), .oldWord(oldWord), .newWord(newWord),
    .selMask(selMask), .mergeWord(mergeWord)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    loadStb = 0; swapStb = 0; shiftStb = 0; shiftLeft = 0; selStb = 0;
    loadTgt = 0; segIdx = 0; segData = 0; selIn = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic load(input logic [1:0] tgt, input logic [1:0] seg, input logic [15:0] d);
    @(negedge clk);
    loadStb = 1; loadTgt = tgt; segIdx = seg; segData = d;
    tick();
  endtask

  task automatic load64(input logic [1:0] tgt, input logic [63:0] v);
    for (int s = 0; s < 4; s++) load(tgt, 2'(s), v[s*16 +: 16]);
  endtask

  task automatic choose(input logic [1:0] code);
    @(negedge clk); selStb = 1; selIn = code;
    tick();
  endtask

  task automatic swap();
    @(negedge clk); swapStb = 1;
    tick();
  endtask

  task automatic shift(input logic up);
    @(negedge clk); shiftStb = 1; shiftLeft = up;
    tick();
  endtask

  task automatic t_reset();
    rstN = 0; idle();
    oldWord = '1; newWord = 64'h0123_4567_89AB_CDEF;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    chk("R1 selMask after reset", selMask, 64'h0);
    chk("R1 merge after reset", mergeWord, 64'h0123_4567_89AB_CDEF);
    choose(2'd1);
    chk("R1 mask1 zero after reset", selMask, 64'h0);
    choose(2'd2);
    chk("R1 mask2 zero after reset", selMask, 64'h0);
  endtask

  task automatic t_load();
    choose(2'd1);
    load(2'd0, 2'd0, 16'h1111);
    chk("R2 seg0 to bits 15..0", selMask, 64'h0000_0000_0000_1111);
    load(2'd0, 2'd3, 16'hA5C3);
    chk("R2 seg3 to bits 63..48", selMask, 64'hA5C3_0000_0000_1111);
    load(2'd0, 2'd1, 16'hBEEF);
    load(2'd0, 2'd2, 16'h7E57);
    chk("R2 all segments", selMask, 64'hA5C3_7E57_BEEF_1111);
    load(2'd3, 2'd1, 16'hFFFF);
    chk("R2 target 3 ignored", selMask, 64'hA5C3_7E57_BEEF_1111);
    choose(2'd2);
    chk("R2 target 3 leaves mask2", selMask, 64'h0);
  endtask

  task automatic t_swap();
    choose(2'd1);
    load64(2'd1, 64'hF0F0_0000_FFFF_000F);
    chk("R4 background load hidden", selMask, 64'hA5C3_7E57_BEEF_1111);
    swap();
    chk("R3 swap shows background", selMask, 64'hF0F0_0000_FFFF_000F);
    swap();
    chk("R3 second swap restores", selMask, 64'hA5C3_7E57_BEEF_1111);
  endtask

  task automatic t_shift();
    choose(2'd2);
    load64(2'd2, 64'h8000_0000_0000_0001);
    chk("R2 mask2 load", selMask, 64'h8000_0000_0000_0001);
    shift(1'b1);
    chk("R5 left drops bit63, zero in", selMask, 64'h0000_0000_0000_0002);
    load(2'd2, 2'd3, 16'hC000);
    shift(1'b0);
    chk("R6 right zero into bit63", selMask, 64'h6000_0000_0000_0001);
    shift(1'b0);
    chk("R6 right drops bit0", selMask, 64'h3000_0000_0000_0000);
  endtask

  task automatic t_select();
    choose(2'd3);
    chk("R7 code 3 gives no mask", selMask, 64'h0);
    choose(2'd1);
    @(negedge clk); newWord = 64'h5555_5555_5555_5555;
    chk("R7 choice held without selStb", selMask, 64'hA5C3_7E57_BEEF_1111);
    choose(2'd0);
    chk("R7 code 0 gives no mask", selMask, 64'h0);
    chk("R8 no mask passes new", mergeWord, 64'h5555_5555_5555_5555);
  endtask

  task automatic t_merge();
    choose(2'd1);
    @(negedge clk);
    oldWord = 64'hFFFF_FFFF_FFFF_FFFF;
    newWord = 64'h0;
    #0.5 chk("R8 merge keeps masked old", mergeWord, 64'hA5C3_7E57_BEEF_1111);
    oldWord = 64'h0;
    newWord = 64'h1234_5678_9ABC_DEF0;
    #0.5 chk("R8 merge takes unmasked new", mergeWord, 64'h1234_5678_9ABC_DEF0 & ~64'hA5C3_7E57_BEEF_1111);
  endtask

  task automatic t_prio();
    choose(2'd1);
    @(negedge clk); loadStb = 1; loadTgt = 2'd0; segIdx = 2'd0; segData = 16'h2222; swapStb = 1;
    tick();
    chk("R9 load wins over swap", selMask, 64'hA5C3_7E57_BEEF_2222);
    choose(2'd2);
    @(negedge clk); swapStb = 1; shiftStb = 1; shiftLeft = 1; selStb = 1; selIn = 2'd2;
    tick();
    chk("R9 swap drops shift", selMask, 64'h3000_0000_0000_0000);
    @(negedge clk); loadStb = 1; loadTgt = 2'd3; shiftStb = 1; shiftLeft = 0;
    tick();
    chk("R9 target-3 load drops shift", selMask, 64'h3000_0000_0000_0000);
    choose(2'd1);
    chk("R9 swap happened, selStb independent", selMask, 64'hF0F0_0000_FFFF_000F);
  endtask

  initial begin
    t_reset();
    t_load();
    t_swap();
    t_shift();
    t_select();
    t_merge();
    t_prio();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule